// File: doc/BRIEF.md
# HDB3/AMI Line Encoder

This block turns a serial NRZ unipolar bit stream into two unipolar return-to-zero rails. One rail carries positive pulses and the other carries negative pulses. Logic outside the block merges the two rails into a ternary line signal. The input bit is captured on the falling edge of the transmit clock. Each encoded symbol leaves on a rising edge and is high only while the clock is high. This gives half-bit pulses when the clock duty cycle is 50 %.

A mode input selects between two codings. In HDB3 coding, every run of four zeros is replaced by a substitution pattern, either 000V or B00V. In plain AMI coding there is no substitution. The block keeps a look-ahead window of four bits: the freshly sampled bit plus three queued bits. A run of four zeros is therefore recognised before its first zero is emitted. The block stores the polarity of the last mark and of the last violation. Those two stored polarities choose between 000V and B00V, so that successive violations alternate in polarity.

Top module: `hdb3_line_encoder`

## Requirements
- R1: `nrz_in` is sampled on the falling edge of `tx_clk`.
- R2: The symbol for a bit sampled on a falling edge is launched on the rising edge 3.5 clock periods later. A zero that is not part of a substitution is sent as a space (both rails low).
- R3: In both modes, each one is sent as a mark of opposite polarity to the previous mark. A positive mark appears on `pos_rail` and a negative mark on `neg_rail`.
- R4: With `hdb3_mode` = 1, the fourth zero of a run of four is sent as a violation. A violation is a mark of the same polarity as the mark sent just before it. Runs are counted from the last one or the last violation.
- R5: With `hdb3_mode` = 1, the first zero of such a run is sent as a normal mark (opposite to the previous mark) when the previous mark's polarity equals the previous violation's polarity. Otherwise the first zero is a space. The second and third zeros are always spaces. As a result, successive violations alternate in polarity.
- R6: With `hdb3_mode` = 0, no zero is ever replaced. Zero runs of any length are sent as spaces.
- R7: Both rails are low whenever `tx_clk` is low (return-to-zero).
- R8: Reset is synchronous and active low (`rst_n`). Both rails are low at every rising edge where reset is sampled low. After release, the encoder behaves as if three zeros preceded the first sampled bit. The stored mark polarity starts negative and the stored violation polarity starts positive. So the first mark is positive, and a first substitution with no earlier mark is 000 followed by a negative violation.
- R9: `pos_rail` and `neg_rail` are never high at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tx_clk | input | 1 | Transmit bit clock; input sampled on the falling edge, output launched on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| hdb3_mode | input | 1 | 1 selects HDB3 substitution, 0 selects plain AMI |
| nrz_in | input | 1 | Serial NRZ unipolar data |
| pos_rail | output | 1 | Positive-pulse return-to-zero rail |
| neg_rail | output | 1 | Negative-pulse return-to-zero rail |

## Verification
The bench targets the following corner cases:
- Back-to-back zero runs. A window that counts a freshly placed violation as a zero would substitute too early and shift every later violation.
- Runs that follow an odd or an even number of marks. A wrong comparison between last-mark and last-violation polarity would emit 000V where B00V is needed, and two violations of the same polarity would appear in a row.
- A stream that starts with zeros right after reset. This exposes a wrong reset polarity pair as a positive first violation or a spurious B.
- AMI runs longer than four zeros. Any leaked substitution shows up as a pulse where only spaces belong.

Every symbol is compared at the rising edge the latency rule predicts, so a pipeline one stage too long or too short fails on the first mark. The low clock phase is checked for pulses that fail to return to zero.

// File: rtl/hdb3_enc_pkg.sv
// Package: shared types for the HDB3/AMI line encoder.
// Assumes: single transmit clock domain; polarity bit 1 means positive.
package hdb3_enc_pkg;

    // One queued bit of the look-ahead window.
    typedef struct packed {
        logic one;   // original NRZ bit was a one
        logic viol;  // zero replaced by a violation pulse
    } slot_t;

    localparam logic POL_POS = 1'b1;
    localparam logic POL_NEG = 1'b0;

endpackage

// File: rtl/hdb3_nrz_sampler.sv
// Module: hdb3_nrz_sampler
// Captures the serial NRZ input on the falling edge of the transmit clock,
// half a period before the rising-edge pipeline reads it.
// Assumes: nrz_in is stable around the falling edge; reset is synchronous.
module hdb3_nrz_sampler (
    input  logic tx_clk,
    input  logic rst_n,
    input  logic nrz_in,
    output logic nrz_bit
);

    // Falling-edge capture of the incoming data bit.
    always_ff @(negedge tx_clk) begin
        if (!rst_n) nrz_bit <= 1'b0;
        else        nrz_bit <= nrz_in;
    end

endmodule

// File: rtl/hdb3_zero_window.sv
// Module: hdb3_zero_window
// Holds DEPTH queued bits on the rising edge. The fresh bit and the DEPTH
// queued bits together form the look-ahead window. When all of them are
// plain zeros in HDB3 mode, the fresh bit is tagged as a violation, and the
// oldest bit (emitted at this same edge) is flagged as the run's first zero.
// Assumes: hdb3_mode is steady while a run is inside the window.
module hdb3_zero_window
    import hdb3_enc_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic  tx_clk,
    input  logic  rst_n,
    input  logic  hdb3_mode,
    input  logic  new_bit,
    output slot_t oldest,
    output logic  first_zero
);

    slot_t slots [DEPTH];
    logic  all_plain_zero;
    logic  sub_now;

    // Detects a window made only of plain zeros.
    always_comb begin
        all_plain_zero = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            if (slots[i].one || slots[i].viol) all_plain_zero = 1'b0;
        end
        sub_now = hdb3_mode && !new_bit && all_plain_zero;
    end

    // Shifts the window by one bit and tags new violations.
    always_ff @(posedge tx_clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
        end else begin
            slots[0] <= '{one: new_bit, viol: sub_now};
            for (int i = 1; i < DEPTH; i++) slots[i] <= slots[i-1];
        end
    end

    assign oldest     = slots[DEPTH-1];
    assign first_zero = sub_now;

    // Checks that the slots behind a fresh violation hold only plain zeros.
    logic zeros_behind;
    always_comb begin
        zeros_behind = 1'b1;
        for (int i = 1; i < DEPTH; i++) begin
            if (slots[i].one || slots[i].viol) zeros_behind = 1'b0;
        end
    end

    // R6
    ami_no_sub_chk: assert property (@(posedge tx_clk) disable iff (!rst_n)
        !hdb3_mode |=> !slots[0].viol);

    // R4
    viol_after_zero_run_chk: assert property (@(posedge tx_clk) disable iff (!rst_n)
        slots[0].viol |-> zeros_behind);

endmodule

// File: rtl/hdb3_pulse_former.sv
// Module: hdb3_pulse_former
// Turns the oldest window bit into a registered polarity decision. It keeps
// the polarity of the last mark and of the last violation. Data ones and
// substituted B pulses alternate against the last mark. V pulses repeat the
// last mark and update the last violation.
// Assumes: first_zero is valid in the same cycle as cur.
module hdb3_pulse_former
    import hdb3_enc_pkg::*;
(
    input  logic  tx_clk,
    input  logic  rst_n,
    input  slot_t cur,
    input  logic  first_zero,
    output logic  pos_q,
    output logic  neg_q
);

    logic last_mark, last_viol;
    logic nxt_mark, nxt_viol;
    logic fire, pol;

    // Picks the pulse for the current bit and the next polarity state.
    always_comb begin
        nxt_mark = last_mark;
        nxt_viol = last_viol;
        fire     = 1'b0;
        pol      = POL_NEG;
        if (cur.viol) begin
            fire     = 1'b1;
            pol      = last_mark;
            nxt_viol = last_mark;
        end else if (cur.one || (first_zero && (last_mark == last_viol))) begin
            fire     = 1'b1;
            pol      = ~last_mark;
            nxt_mark = ~last_mark;
        end
    end

    // Registers the pulse and the polarity state.
    always_ff @(posedge tx_clk) begin
        if (!rst_n) begin
            last_mark <= POL_NEG;
            last_viol <= POL_POS;
            pos_q     <= 1'b0;
            neg_q     <= 1'b0;
        end else begin
            last_mark <= nxt_mark;
            last_viol <= nxt_viol;
            pos_q     <= fire && (pol == POL_POS);
            neg_q     <= fire && (pol == POL_NEG);
        end
    end

    // R5
    viol_alternates_chk: assert property (@(posedge tx_clk) disable iff (!rst_n)
        cur.viol |-> (last_mark != last_viol));

endmodule

// File: rtl/hdb3_line_encoder.sv
// Module: hdb3_line_encoder (top)
// NRZ-to-HDB3/AMI encoder with two return-to-zero output rails. The input
// is sampled on the falling edge. The symbol leaves on the rising edge
// RUN_LEN-0.5 periods later, which is 3.5 periods for the default run of four.
// Assumes: rails are merged externally; the clock has a 50 % duty cycle for
// half-bit pulses.
module hdb3_line_encoder
    import hdb3_enc_pkg::*;
#(
    parameter int RUN_LEN = 4
) (
    input  logic tx_clk,
    input  logic rst_n,
    input  logic hdb3_mode,
    input  logic nrz_in,
    output logic pos_rail,
    output logic neg_rail
);

    localparam int DEPTH = RUN_LEN - 1;

    logic  nrz_bit;
    slot_t oldest;
    logic  first_zero;
    logic  pos_q, neg_q;

    hdb3_nrz_sampler u_sampler (
        .tx_clk (tx_clk),
        .rst_n  (rst_n),
        .nrz_in (nrz_in),
        .nrz_bit(nrz_bit)
    );

    hdb3_zero_window #(.DEPTH(DEPTH)) u_window (
        .tx_clk    (tx_clk),
        .rst_n     (rst_n),
        .hdb3_mode (hdb3_mode),
        .new_bit   (nrz_bit),
        .oldest    (oldest),
        .first_zero(first_zero)
    );

    hdb3_pulse_former u_former (
        .tx_clk    (tx_clk),
        .rst_n     (rst_n),
        .cur       (oldest),
        .first_zero(first_zero),
        .pos_q     (pos_q),
        .neg_q     (neg_q)
    );

    // Return-to-zero shaping: a pulse is only visible in the high clock phase.
    assign pos_rail = pos_q & tx_clk;
    assign neg_rail = neg_q & tx_clk;

    // R9
    rails_exclusive_chk: assert property (@(posedge tx_clk) disable iff (!rst_n)
        !(pos_q && neg_q));

    // R7
    rails_rz_chk: assert property (@(posedge tx_clk) disable iff (!rst_n)
        !pos_rail && !neg_rail);

endmodule

// File: tb/test_hdb3_line_encoder.sv
`timescale 1ns/1ps
// Bench: behavioural reference encoder over the whole bit sequence,
// compared against the rails on every rising edge.
module test_hdb3_line_encoder;

    logic tx_clk = 1'b0;
    logic rst_n = 1'b0;
    logic hdb3_mode = 1'b1;
    logic nrz_in = 1'b0;
    logic pos_rail, neg_rail;

    int checks = 0;
    int failures = 0;
    int bits[$];
    int exp_sym[$];
    int exp_kind[$];   // 0 space, 1 data mark, 2 B, 3 V
    int first_pulse;

    always #2.5 tx_clk = ~tx_clk;

    hdb3_line_encoder i_hdb3_line_encoder (
        .tx_clk   (tx_clk),
        .rst_n    (rst_n),
        .hdb3_mode(hdb3_mode),
        .nrz_in   (nrz_in),
        .pos_rail (pos_rail),
        .neg_rail (neg_rail)
    );

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Reference: three leading zeros (reset state), the bits, trailing zeros.
    task automatic build_expected(bit mode);
        int stream[$];
        int last_mark = -1;
        int last_viol = 1;
        int z = 0;
        stream = {0, 0, 0};
        foreach (bits[k]) stream.push_back(bits[k]);
        for (int k = 0; k < 8; k++) stream.push_back(0);
        exp_sym.delete();
        exp_kind.delete();
        first_pulse = -1;
        for (int i = 0; i < stream.size(); i++) begin
            int sym = 0;
            int kind = 0;
            if (stream[i] == 1) begin
                sym = -last_mark; last_mark = sym; kind = 1; z = 0;
            end else begin
                z++;
                if (mode && z == 4) begin
                    if (last_mark == last_viol) begin
                        exp_sym[i-3] = -last_mark;
                        exp_kind[i-3] = 2;
                        last_mark = -last_mark;
                    end
                    sym = last_mark; last_viol = last_mark; kind = 3; z = 0;
                end
            end
            exp_sym.push_back(sym);
            exp_kind.push_back(kind);
        end
        foreach (exp_sym[i]) if (first_pulse < 0 && exp_sym[i] != 0) first_pulse = i;
    endtask

    function automatic string tag_of(bit mode, int idx);
        if (idx < 3 || idx == first_pulse) return "R8";
        if (!mode) return "R6";
        case (exp_kind[idx])
            1: return "R1 R3";
            2: return "R5";
            3: return "R4";
            default: return "R2";
        endcase
    endfunction

    task automatic add_pattern(string s);
        for (int i = 0; i < s.len(); i++) bits.push_back(s[i] == "1" ? 1 : 0);
    endtask

    task automatic add_sparse(int n, int unsigned seed);
        int unsigned x = seed;
        for (int i = 0; i < n; i++) begin
            x = x * 1103515245 + 12345;
            bits.push_back(((x >> 16) % 3 == 0) ? 1 : 0);
        end
    endtask

    task automatic run_segment(bit mode);
        int n = bits.size();
        build_expected(mode);
        rst_n = 1'b0;
        hdb3_mode = mode;
        nrz_in = 1'b0;
        repeat (3) @(posedge tx_clk);
        #1;
        // R8: rails low during reset
        check(!pos_rail && !neg_rail, "R8", "rails in reset", {pos_rail, neg_rail}, 0);
        for (int c = 0; c <= n + 3; c++) begin
            @(posedge tx_clk);
            #1;
            if (c >= 1) begin
                int act = pos_rail ? 1 : (neg_rail ? -1 : 0);
                // R9: never both rails at once
                check(!(pos_rail && neg_rail), "R9", "both rails high", 1, 0);
                check(act == exp_sym[c-1], tag_of(mode, c-1), "symbol", act, exp_sym[c-1]);
            end
            if (c == 0) rst_n = 1'b1;
            nrz_in = (c < n) ? bits[c][0] : 1'b0;
            #2.5;
            // R7: low clock phase carries no pulse
            check(!pos_rail && !neg_rail, "R7", "rails in low phase", {pos_rail, neg_rail}, 0);
        end
        bits.delete();
    endtask

    initial begin
        #(5.0 * 150000);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // HDB3: runs after odd and even mark counts, back-to-back runs
        add_pattern("1000011000000001010010000110000100000000000011100001");
        add_sparse(150, 32'd7);
        run_segment(1'b1);
        // HDB3 straight after reset: leading zeros give 000V with negative V
        add_pattern("0000000010000");
        run_segment(1'b1);
        // HDB3 extremes: all ones, then a long zero stretch
        add_pattern("11111111000000000000000000001");
        run_segment(1'b1);
        // AMI: long zero runs must stay spaces
        add_pattern("1000011000000001010010000000000111");
        add_sparse(100, 32'd99);
        run_segment(1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule